// File: doc/BRIEF.md
# Falling-Edge Event Counter with Atomic Read-and-Clear

This block counts falling edges seen on an asynchronous input pin and keeps the total in a wrapping accumulator, 32 bits wide by default. The pin is first brought into the clock domain through a two-stage synchronizer. A falling edge is then found by comparing the synchronized level with its value one cycle earlier.

A host reaches the count through a single command strobe that carries two flags. The read flag captures the count onto the result port. The clear flag returns the accumulator to zero. When both flags are set, the host gets the count from just before the clear. An edge that arrives in the clear cycle is neither lost nor counted twice: it becomes the first event of the new epoch.

A separate initialize pulse, which comes from a global configuration update, also sets the accumulator to zero. It is handled in the same way as a clear.

Top module: `falling_edge_counter`

## Requirements
- R1: While rst_ni is low, value_o is 0 and valid_o is 0, and the count is 0 once reset is released.
- R2: Each high-to-low transition of pin_i adds exactly one to the count when each pin level lasts at least two clock cycles. Rising edges and steady levels leave the count unchanged.
- R3: A command sampled with cmd_valid_i=1 and cmd_read_i=1 sets valid_o high for exactly the following cycle. value_o holds the captured count until the next read, and valid_o is low in every other cycle.
- R4: A command with cmd_valid_i=1 and cmd_clear_i=1 sets the count to zero.
- R5: With cmd_read_i=1 and cmd_clear_i=1 in the same command, value_o returns the count from before the clear, and a later read returns only the edges that arrived after it.
- R6: A one-cycle pulse on init_i sets the count to zero whatever the state of cmd_valid_i.
- R7: A detected falling edge in the same cycle as a clear or an initialize leaves the count at 1.
- R8: The count wraps modulo 2^CNT_W.
- R9: While cmd_valid_i is 0, cmd_read_i and cmd_clear_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous event pin |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_read_i | input | 1 | Capture the count with the command |
| cmd_clear_i | input | 1 | Zero the count with the command |
| init_i | input | 1 | Configuration re-initialize pulse |
| value_o | output | CNT_W | Captured count |
| valid_o | output | 1 | One-cycle pulse when value_o is updated |

## Verification
The hardest case to reach from the ports is a clear or an initialize that lands in the very cycle the synchronized edge is detected. The detection happens two clock edges after the pin changes, so it cannot be seen from outside. The bench drives the pin low on a falling clock edge, counts two rising edges, and then applies the command so that it is sampled on the third edge; the next read must return 1. Wrap-around is covered by a second, 4-bit instance that shares the stimulus of a sweep of growing edge batches.

// File: rtl/fec_pkg.sv
package fec_pkg;
  parameter int unsigned FEC_CNT_W  = 32;
  parameter int unsigned FEC_STAGES = 2;

  typedef struct packed {
    logic rd;
    logic clr;
  } fec_cmd_t;
endpackage

// File: rtl/fec_sync.sv
module fec_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fec_fall_detect.sv
module fec_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;

  assign fall_o = prev_q & ~lvl_i;

  AST_FALL_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/fec_accum.sv
module fec_accum #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             clr_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] value_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  // edge in the clear cycle opens the new epoch
  always_comb begin
    count_d = count_q;
    if (clr_i)       count_d = {{(CNT_W-1){1'b0}}, fall_i};
    else if (fall_i) count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      value_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= rd_i;
      if (rd_i) value_o <= count_q;
    end

  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !clr_i) |=> $stable(count_q)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !clr_i) |=> (count_q - $past(count_q)) == CNT_W'(1)); // R8
  AST_CLEAR_EPOCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q <= CNT_W'(1)) && (count_q[0] == $past(fall_i))); // R7
  AST_READ_PRECLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> valid_o && (value_o == $past(count_q))); // R5
  AST_VALID_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !valid_o && $stable(value_o)); // R3
endmodule

// File: rtl/falling_edge_counter.sv
module falling_edge_counter
  import fec_pkg::*;
#(
  parameter int unsigned CNT_W  = FEC_CNT_W,
  parameter int unsigned STAGES = FEC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_read_i,
  input  logic             cmd_clear_i,
  input  logic             init_i,
  output logic [CNT_W-1:0] value_o,
  output logic             valid_o
);
  fec_cmd_t cmd;
  logic     pin_sync;
  logic     fall;
  logic     clr;

  assign cmd.rd  = cmd_valid_i & cmd_read_i;
  assign cmd.clr = cmd_valid_i & cmd_clear_i;
  assign clr     = cmd.clr | init_i;

  fec_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  fec_fall_detect u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_sync),
    .fall_o(fall)
  );

  fec_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .clr_i  (clr),
    .rd_i   (cmd.rd),
    .value_o(value_o),
    .valid_o(valid_o)
  );

  AST_IDLE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !valid_o); // R9
  AST_RESET_OUT: assert property (@(posedge clk_i)
    !rst_ni |-> (value_o == '0) && !valid_o); // R1
endmodule

// File: tb/falling_edge_counter_test.sv
`timescale 1ns/1ps
module falling_edge_counter_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pin = 1'b1;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_clear = 1'b0, init = 1'b0;
  logic [31:0] value;
  logic        valid;
  logic [3:0]  value_n;
  logic        valid_n;
  int checks = 0;
  int errors = 0;
  int total;

  always #4 clk = ~clk;

  falling_edge_counter uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .cmd_valid_i(cmd_valid),
    .cmd_read_i(cmd_read), .cmd_clear_i(cmd_clear), .init_i(init),
    .value_o(value), .valid_o(valid));

  falling_edge_counter #(.CNT_W(4)) uut_nar (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .cmd_valid_i(cmd_valid),
    .cmd_read_i(cmd_read), .cmd_clear_i(cmd_clear), .init_i(init),
    .value_o(value_n), .valid_o(valid_n));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b0; @(negedge clk); @(negedge clk);
      pin = 1'b1; @(negedge clk); @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic command(input bit rd, input bit clr);
    cmd_valid = 1'b1; cmd_read = rd; cmd_clear = clr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_read = 1'b0; cmd_clear = 1'b0;
  endtask

  task automatic read_expect(input string req, input longint exp, input bit clr);
    command(1'b1, clr);
    check(valid && valid_n, {req, " valid"}, valid, 1);
    check(value == exp[31:0], req, value, exp[31:0]);
    check(value_n == exp[3:0], {req, " narrow"}, value_n, exp[3:0]);
    @(negedge clk);
    check(!valid && !valid_n, "R3 single pulse", valid, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(value == 0 && !valid && value_n == 0 && !valid_n, "R1 reset", value, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_expect("R1 count after reset", 0, 1'b0);

    // R5 / R4 / R8 sweep of batch sizes
    for (int k = 0; k <= 20; k++) begin
      edges(k);
      read_expect("R5 read-clear returns batch", k, 1'b1);
      read_expect("R4 zero after clear", 0, 1'b0);
    end

    // R8 wrap in narrow instance, wide keeps going
    edges(20);
    read_expect("R8 wrap", 20, 1'b0);

    // R2 steady high then rising-only segment
    repeat (10) @(negedge clk);
    read_expect("R2 steady level", 20, 1'b0);
    pin = 1'b0; repeat (5) @(negedge clk);
    read_expect("R2 fall counted once", 21, 1'b0);
    pin = 1'b1; repeat (6) @(negedge clk);
    read_expect("R2 rising ignored", 21, 1'b0);

    // R3 value held between reads
    repeat (5) @(negedge clk);
    check(value == 21 && !valid, "R3 held value", value, 21);

    // R9 flags without strobe
    cmd_read = 1'b1; cmd_clear = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!valid && value == 21, "R9 no strobe", valid, 0);
    end
    cmd_read = 1'b0; cmd_clear = 1'b0;
    read_expect("R9 count intact", 21, 1'b0);

    // R6 initialize pulse
    edges(3);
    init = 1'b1; @(negedge clk); init = 1'b0;
    read_expect("R6 init zeroes", 0, 1'b0);
    edges(2);
    read_expect("R6 counts after init", 2, 1'b0);

    // R7 edge coincident with clear
    pin = 1'b0;
    @(negedge clk); @(negedge clk);
    command(1'b1, 1'b1);
    check(value == 2, "R7 pre-clear value", value, 2);
    repeat (4) @(negedge clk);
    read_expect("R7 clear plus edge", 1, 1'b0);
    pin = 1'b1; repeat (4) @(negedge clk);

    // R7 edge coincident with init
    pin = 1'b0;
    @(negedge clk); @(negedge clk);
    init = 1'b1; @(negedge clk); init = 1'b0;
    repeat (4) @(negedge clk);
    read_expect("R7 init plus edge", 1, 1'b0);
    pin = 1'b1; repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule